// File: doc/BRIEF.md
# Fence Sequence Write-Back Unit

This block sits on a command stream's method-write path and turns a short run of register writes into a fence. A producer loads a 64-bit target address as two 32-bit halves, loads a sequence number, and then writes a packed control word. When the mode field of that control word asks for a write, the block issues one 32-bit memory write that carries the loaded sequence number to the loaded address. The method input is held off while that write is outstanding.

A host that waits on the fence polls the memory word and feeds the value it reads into the block. The block compares that value against the sequence number of the last write that memory accepted and raises a done flag when the polled value has caught up. Sequence numbers grow by one per submitted list, so an unsigned greater-or-equal test is the completion rule. A control word in sync mode completes without touching memory. A target address that is not word aligned raises an error flag and suppresses the write.

Top module: `fence_writeback`

## Requirements
- R1: After reset `meth_ready_o` is 1, `wr_valid_o` is 0, `err_o` is 0, and `fence_done_o` is 1 for any polled value, because the last acknowledged sequence resets to 0.
- R2: Method index `BASE_IDX+0` loads the address high half, `BASE_IDX+1` the address low half, `BASE_IDX+2` the sequence, and `BASE_IDX+3` the control word. A write to any other index changes no stored value and starts no memory write.
- R3: An accepted control write whose bits 1:0 are 0, with a word-aligned address, raises `wr_valid_o` in the cycle after acceptance. The request carries `wr_addr_o = {high, low}` and `wr_data_o = sequence`. Exactly one request is made for each such control write.
- R4: Control modes 2 and 3 behave as mode 0. The fence flag (bit 4) and the unit field (bits 15:12) do not change whether the write happens or what it carries.
- R5: A control write with mode 1 (sync) makes no memory write. It leaves `meth_ready_o` high, leaves `err_o` unchanged, and does not change the sequence used for completion.
- R6: While a request is pending (`wr_valid_o` high and `wr_ready_i` low), `meth_ready_o` is 0, and `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values until the handshake.
- R7: A write-mode control write when address bits 1:0 are not both zero sets `err_o` and makes no request. The next write-mode control write with an aligned address clears `err_o`.
- R8: `fence_done_o` is 1 exactly when `poll_value_i`, taken as unsigned, is greater than or equal to the data of the last request completed on the memory handshake. That value updates on the handshake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| meth_valid_i | input | 1 | Method write offered |
| meth_ready_o | output | 1 | Method write can be accepted |
| meth_idx_i | input | IDX_W | Method index |
| meth_data_i | input | DATA_W | Method data word |
| wr_valid_o | output | 1 | Memory write request valid |
| wr_ready_i | input | 1 | Memory accepts the request |
| wr_addr_o | output | 2*DATA_W | Byte address of the write |
| wr_data_o | output | DATA_W | Sequence value to store |
| err_o | output | 1 | Last write-mode request had a misaligned address |
| poll_value_i | input | DATA_W | Value the host read back from the fence word |
| fence_done_o | output | 1 | Polled value has reached the last issued sequence |

## Verification
The write path is tried with every write-mode code, with the fence and unit fields both clear and set, and with zero and several cycles of memory back-pressure. This separates mode decoding from the payload and from the hold-off logic. Sync words, misaligned low halves and writes to indices just outside the register window each confirm that no request appears and that the stored state survives. A later control-only write exposes any stored value that a stray write corrupted. The done flag is probed just below, at and above the last sequence, including the all-ones value, to pin down the unsigned comparison and its update point.

// File: rtl/fence_wb_pkg.sv
package fence_wb_pkg;

    // Mode field of the control word (bits 1:0)
    typedef enum logic [1:0] {
        QM_WRITE      = 2'd0,
        QM_SYNC       = 2'd1,
        QM_WRITE_ALT2 = 2'd2,
        QM_WRITE_ALT3 = 2'd3
    } qmode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } wb_state_e;

    // Register slots relative to the base method index; order is fixed
    localparam int unsigned NUM_SLOTS = 4;
    localparam int unsigned SLOT_ADDR_HI = 0;
    localparam int unsigned SLOT_ADDR_LO = 1;
    localparam int unsigned SLOT_SEQ     = 2;
    localparam int unsigned SLOT_CTRL    = 3;

    function automatic logic mode_writes(qmode_e m);
        return m != QM_SYNC;
    endfunction

endpackage

// File: rtl/fence_wb_regs.sv
module fence_wb_regs
    import fence_wb_pkg::*;
#(
    parameter int unsigned IDX_W    = 13,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned BASE_IDX = 'h6C0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] addr_hi_o,
    output logic [DATA_W-1:0] addr_lo_o,
    output logic [DATA_W-1:0] seq_o,
    output logic              ctrl_hit_o,
    output logic [1:0]        ctrl_mode_o
);

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] seq;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_SLOTS-1:0] slot_hit;

    // One decoder per slot
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_hit[s] = wr_en_i && (idx_i == IDX_W'(BASE_IDX + s));
    end

    always_comb begin
        regs_d = regs_q;
        if (slot_hit[SLOT_ADDR_HI]) regs_d.hi  = data_i;
        if (slot_hit[SLOT_ADDR_LO]) regs_d.lo  = data_i;
        if (slot_hit[SLOT_SEQ])     regs_d.seq = data_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign addr_hi_o   = regs_q.hi;
    assign addr_lo_o   = regs_q.lo;
    assign seq_o       = regs_q.seq;
    assign ctrl_hit_o  = slot_hit[SLOT_CTRL];
    assign ctrl_mode_o = data_i[1:0];

endmodule

// File: rtl/fence_wb_ctrl.sv
module fence_wb_ctrl
    import fence_wb_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ctrl_hit_i,
    input  logic [1:0]            ctrl_mode_i,
    input  logic [ALIGN_BITS-1:0] addr_lsb_i,
    input  logic                  wr_ready_i,
    output logic                  busy_o,
    output logic                  wr_valid_o,
    output logic                  err_o,
    output logic                  ack_o
);

    typedef struct packed {
        wb_state_e state;
        logic      err;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  ack;

    always_comb begin
        ctrl_d = ctrl_q;
        ack    = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (ctrl_hit_i && mode_writes(qmode_e'(ctrl_mode_i))) begin
                    if (|addr_lsb_i) begin
                        ctrl_d.err = 1'b1;
                    end else begin
                        ctrl_d.err   = 1'b0;
                        ctrl_d.state = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (wr_ready_i) begin
                    ctrl_d.state = ST_IDLE;
                    ack          = 1'b1;
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctrl_q <= '{state: ST_IDLE, err: 1'b0};
        else         ctrl_q <= ctrl_d;
    end

    assign busy_o     = (ctrl_q.state == ST_ISSUE);
    assign wr_valid_o = (ctrl_q.state == ST_ISSUE);
    assign err_o      = ctrl_q.err;
    assign ack_o      = ack;

endmodule

// File: rtl/fence_wb_cmp.sv
module fence_wb_cmp #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] seq_i,
    input  logic [DATA_W-1:0] poll_i,
    output logic              done_o
);

    typedef struct packed {
        logic [DATA_W-1:0] last;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (ack_i) cmp_d.last = seq_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cmp_q <= '0;
        else         cmp_q <= cmp_d;
    end

    // Unsigned: sequence numbers only grow
    assign done_o = (poll_i >= cmp_q.last);

endmodule

// File: rtl/fence_writeback.sv
module fence_writeback
    import fence_wb_pkg::*;
#(
    parameter int unsigned IDX_W      = 13,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned BASE_IDX   = 'h6C0,
    parameter int unsigned ALIGN_BITS = 2,
    localparam int unsigned ADDR_W    = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              meth_valid_i,
    output logic              meth_ready_o,
    input  logic [IDX_W-1:0]  meth_idx_i,
    input  logic [DATA_W-1:0] meth_data_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              err_o,
    input  logic [DATA_W-1:0] poll_value_i,
    output logic              fence_done_o
);

    logic              accept;
    logic              busy;
    logic              ctrl_hit;
    logic [1:0]        ctrl_mode;
    logic              ack;
    logic [DATA_W-1:0] addr_hi, addr_lo, seq;

    assign meth_ready_o = !busy;
    assign accept       = meth_valid_i && meth_ready_o;

    fence_wb_regs #(
        .IDX_W   (IDX_W),
        .DATA_W  (DATA_W),
        .BASE_IDX(BASE_IDX)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (accept),
        .idx_i      (meth_idx_i),
        .data_i     (meth_data_i),
        .addr_hi_o  (addr_hi),
        .addr_lo_o  (addr_lo),
        .seq_o      (seq),
        .ctrl_hit_o (ctrl_hit),
        .ctrl_mode_o(ctrl_mode)
    );

    fence_wb_ctrl #(
        .ALIGN_BITS(ALIGN_BITS)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ctrl_hit_i (ctrl_hit),
        .ctrl_mode_i(ctrl_mode),
        .addr_lsb_i (addr_lo[ALIGN_BITS-1:0]),
        .wr_ready_i (wr_ready_i),
        .busy_o     (busy),
        .wr_valid_o (wr_valid_o),
        .err_o      (err_o),
        .ack_o      (ack)
    );

    fence_wb_cmp #(
        .DATA_W(DATA_W)
    ) u_cmp (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ack_i (ack),
        .seq_i (seq),
        .poll_i(poll_value_i),
        .done_o(fence_done_o)
    );

    // Registers cannot change while busy, so the payload is read directly
    assign wr_addr_o = {addr_hi, addr_lo};
    assign wr_data_o = seq;

endmodule

// File: rtl/fence_writeback_chk.sv
module fence_writeback_chk #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              meth_ready_o,
    input logic              wr_valid_o,
    input logic              wr_ready_i,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              err_o,
    input logic [DATA_W-1:0] poll_value_i,
    input logic              fence_done_o
);

    // R6: input held off while a request is outstanding
    p_hold_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> !meth_ready_o);

    // R6: request stays put until accepted
    p_req_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R7: no request ever targets a misaligned address
    p_aligned_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> (wr_addr_o[1:0] == 2'b00));

    // R7: raising the error flag never coincides with a request
    p_err_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> !wr_valid_o);

    // R8: after a handshake the flag compares against the accepted data
    p_done_tracks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_o && wr_ready_i) |=>
            (fence_done_o == (poll_value_i >= $past(wr_data_o))));

endmodule

bind fence_writeback fence_writeback_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .meth_ready_o(meth_ready_o),
    .wr_valid_o  (wr_valid_o),
    .wr_ready_i  (wr_ready_i),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .err_o       (err_o),
    .poll_value_i(poll_value_i),
    .fence_done_o(fence_done_o)
);

// File: tb/fence_writeback_tb_top.sv
module fence_writeback_tb_top;

    localparam int unsigned IDX_W  = 13;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned BASE   = 'h6C0;
    localparam logic [IDX_W-1:0] I_HI   = IDX_W'(BASE + 0);
    localparam logic [IDX_W-1:0] I_LO   = IDX_W'(BASE + 1);
    localparam logic [IDX_W-1:0] I_SEQ  = IDX_W'(BASE + 2);
    localparam logic [IDX_W-1:0] I_CTRL = IDX_W'(BASE + 3);

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              meth_valid_i = 1'b0;
    logic              meth_ready_o;
    logic [IDX_W-1:0]  meth_idx_i = '0;
    logic [DATA_W-1:0] meth_data_i = '0;
    logic              wr_valid_o;
    logic              wr_ready_i = 1'b0;
    logic [63:0]       wr_addr_o;
    logic [31:0]       wr_data_o;
    logic              err_o;
    logic [31:0]       poll_value_i = '0;
    logic              fence_done_o;

    int total = 0;
    int fails = 0;
    int stall = 0;
    int wait_cnt = 0;
    logic [95:0] exp_q[$];

    always #2 clk_i = ~clk_i;   // 250 MHz

    fence_writeback #(.IDX_W(IDX_W), .DATA_W(DATA_W), .BASE_IDX(BASE)) dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .meth_valid_i(meth_valid_i), .meth_ready_o(meth_ready_o),
        .meth_idx_i(meth_idx_i), .meth_data_i(meth_data_i),
        .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .err_o(err_o), .poll_value_i(poll_value_i), .fence_done_o(fence_done_o)
    );

    task automatic check(input logic ok, input string req,
                         input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory side: accept after `stall` waiting cycles
    always @(posedge clk_i) begin
        #1;
        if (wr_valid_o && !wr_ready_i) begin
            if (wait_cnt >= stall) wr_ready_i = 1'b1;
            else wait_cnt++;
        end else begin
            wr_ready_i = 1'b0;
            wait_cnt = 0;
        end
    end

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk_i);
            if (wr_valid_o && wr_ready_i) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected write", {wr_addr_o, wr_data_o}, '0);
                end else begin
                    logic [95:0] e;
                    e = exp_q.pop_front();
                    check({wr_addr_o, wr_data_o} == e, "R3 write payload",
                          {wr_addr_o, wr_data_o}, e);
                end
            end
        end
    end

    task automatic mwrite(input logic [IDX_W-1:0] idx, input logic [31:0] d);
        @(posedge clk_i); #1;
        meth_valid_i = 1'b1; meth_idx_i = idx; meth_data_i = d;
        @(negedge clk_i);
        while (!meth_ready_o) @(negedge clk_i);
        @(posedge clk_i); #1;
        meth_valid_i = 1'b0;
    endtask

    task automatic fence_cmd(input logic [31:0] hi, input logic [31:0] lo,
                             input logic [31:0] sq, input logic [31:0] ctl,
                             input logic expect_wr);
        mwrite(I_HI, hi);
        mwrite(I_LO, lo);
        mwrite(I_SEQ, sq);
        if (expect_wr) exp_q.push_back({hi, lo, sq});
        mwrite(I_CTRL, ctl);
    endtask

    task automatic wait_idle();
        @(negedge clk_i);
        while (wr_valid_o) @(negedge clk_i);
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i);
            if (wr_valid_o) seen++;
        end
        check(seen == 0, req, 96'(seen), 96'd0);
    endtask

    task automatic done_is(input logic [31:0] p, input logic exp, input string req);
        poll_value_i = p;
        #1;
        check(fence_done_o == exp, req, 96'(fence_done_o), 96'(exp));
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk_i);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(posedge clk_i);
        #1 rst_ni = 1'b1;

        // R1: reset state
        @(negedge clk_i);
        check(meth_ready_o == 1'b1, "R1 ready", 96'(meth_ready_o), 96'd1);
        check(wr_valid_o == 1'b0, "R1 valid", 96'(wr_valid_o), 96'd0);
        check(err_o == 1'b0, "R1 err", 96'(err_o), 96'd0);
        done_is(32'h0, 1'b1, "R1 done");

        // R3: mode 0, aligned, no back-pressure; request one cycle after accept
        stall = 0;
        fence_cmd(32'h0000_0001, 32'h8000_0040, 32'd1, 32'h0000_0000, 1'b1);
        @(negedge clk_i);
        check(wr_valid_o == 1'b1, "R3 valid timing", 96'(wr_valid_o), 96'd1);
        wait_idle();
        done_is(32'd0, 1'b0, "R8 below");
        done_is(32'd1, 1'b1, "R8 equal");
        done_is(32'd2, 1'b1, "R8 above");

        // R6: back-pressure holds the request and blocks the input
        stall = 3;
        fence_cmd(32'hDEAD_BEEF, 32'h0000_1000, 32'd2, 32'h0000_0000, 1'b1);
        @(negedge clk_i);
        held = wr_addr_o;
        for (int i = 0; i < 3; i++) begin
            check(meth_ready_o == 1'b0, "R6 ready low", 96'(meth_ready_o), 96'd0);
            check(wr_valid_o && wr_addr_o == held, "R6 held",
                  {wr_valid_o, wr_addr_o}, {1'b1, held});
            @(negedge clk_i);
        end
        wait_idle();
        check(meth_ready_o == 1'b1, "R6 ready back", 96'(meth_ready_o), 96'd1);

        // R4: modes 2 and 3, fence and unit fields set
        stall = 1;
        fence_cmd(32'h0000_0002, 32'h0000_2004, 32'd3, 32'h0000_0002, 1'b1);
        wait_idle();
        fence_cmd(32'h0000_0003, 32'h0000_2008, 32'd4, 32'h0000_A013, 1'b1);
        wait_idle();
        fence_cmd(32'h0000_0003, 32'h0000_200C, 32'd5, 32'h0000_F010, 1'b1);
        wait_idle();
        done_is(32'd4, 1'b0, "R4 last seq five");
        done_is(32'd5, 1'b1, "R4 reached five");

        // R5: sync issues nothing and does not move the completion point
        fence_cmd(32'h0000_0004, 32'h0000_3000, 32'd9, 32'h0000_F011, 1'b0);
        quiet(6, "R5 no write");
        check(meth_ready_o == 1'b1, "R5 ready", 96'(meth_ready_o), 96'd1);
        done_is(32'd5, 1'b1, "R5 completion unchanged");

        // R7: misaligned low half
        fence_cmd(32'h0000_0005, 32'h0000_3002, 32'd10, 32'h0000_0000, 1'b0);
        @(negedge clk_i);
        check(err_o == 1'b1, "R7 err set", 96'(err_o), 96'd1);
        quiet(6, "R7 no write");
        done_is(32'd5, 1'b1, "R7 completion unchanged");
        mwrite(I_CTRL, 32'h0000_0001);  // sync keeps the error
        @(negedge clk_i);
        check(err_o == 1'b1, "R5 sync keeps err", 96'(err_o), 96'd1);
        fence_cmd(32'h0000_0005, 32'h0000_3001, 32'd10, 32'h0000_0003, 1'b0);
        quiet(4, "R7 odd address no write");
        fence_cmd(32'h0000_0006, 32'h0000_3000, 32'd11, 32'h0000_0000, 1'b1);
        @(negedge clk_i);
        check(err_o == 1'b0, "R7 err cleared", 96'(err_o), 96'd0);
        wait_idle();

        // R2: writes just outside the window change nothing
        mwrite(IDX_W'(BASE + 4), 32'h0000_0000);
        mwrite(IDX_W'(BASE - 1), 32'hFFFF_FFFF);
        quiet(4, "R2 outside window no write");
        exp_q.push_back({32'h0000_0006, 32'h0000_3000, 32'd11});
        mwrite(I_CTRL, 32'h0000_0000);
        wait_idle();

        // R8: all-ones sequence, unsigned compare
        stall = 0;
        fence_cmd(32'h0000_0007, 32'h0000_4000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
        wait_idle();
        done_is(32'hFFFF_FFFE, 1'b0, "R8 all ones below");
        done_is(32'hFFFF_FFFF, 1'b1, "R8 all ones equal");

        repeat (4) @(negedge clk_i);
        check(exp_q.size() == 0, "R3 all writes seen", 96'(exp_q.size()), 96'd0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule